// File: doc/BRIEF.md
# PCM Time-Slot Transmit Port

This block places per-channel samples on a shared time-division PCM highway. It runs on the PCM bit clock, with an 8 kHz frame sync that sets where each frame begins. Each channel is programmed with a slot number, a two-bit port steering field, a wide-burst flag and a 16-bit sample word. During the slots a channel owns, the block drives the sample out on port A, port B or both, most significant bit first. At all other times each port's output-enable is low, so the pad can float.

A cutoff input mutes both ports. An active input and a signaling-mode input together decide whether the block transmits at all. Signaling mode also widens every burst to 16 bits. Sample words are captured once per frame, so one frame never carries parts of two samples.

Top module: `pcm_slot_tx`

## Requirements
- R1: After reset, and until the first frame sync is sampled, both output-enables are low and both data outputs are 0.
- R2: The cycle after the clock edge that samples `fsync` high is clock slot 0 of time slot 0. Time slot N spans the 8 cycles starting 8·N cycles after that.
- R3: A narrow channel (wide flag 0, signaling off) sends bits 7..0 of its word during its slot, bit 7 in the first cycle.
- R4: A wide channel sends bits 15..8 in slot N and bits 7..0 in slot N+1, most significant bit first. If N is the last slot of the frame, only bits 15..8 are sent.
- R5: Port field bit 0 steers the channel to port A and bit 1 steers it to port B. With both bits set, both ports carry the same bits in the same cycles.
- R6: Outside owned slots a port's output-enable is low. Whenever the enable is low, the data output is 0.
- R7: While `cutoff` is high, both output-enables are low.
- R8: With `active` low and `sig_en` low, both output-enables are low. With `sig_en` high, the block transmits even when inactive, and every channel uses the 16-bit burst of R4.
- R9: Sample words are captured at the frame-sync edge. A change to `ch_data` later in the frame first appears on the outputs in the next frame.
- R10: When two channels claim the same slot on the same port, the lower-numbered channel drives it and the other channel is not output there.
- R11: Without a new frame sync, the position wraps after SLOTS·8 cycles and the previously captured samples are sent again in the same slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync pulse, one clock wide |
| active | input | 1 | Block active state |
| sig_en | input | 1 | Signaling mode: forces 16-bit bursts and allows transmission while inactive |
| cutoff | input | 1 | Mutes both ports |
| ch_slot | input | NCH·SW | Start slot of each channel |
| ch_port | input | 2·NCH | Per channel: bit 0 selects port A, bit 1 selects port B |
| ch_wide | input | NCH | Per channel 16-bit burst flag |
| ch_data | input | 16·NCH | Per channel sample word |
| txa | output | 1 | Port A serial data |
| txa_oe | output | 1 | Port A output-enable |
| txb | output | 1 | Port B serial data |
| txb_oe | output | 1 | Port B output-enable |

## Verification
Two things can land in the same cycle: the second byte of a wide burst, and another channel's narrow burst programmed into that same slot on the same port. The bench sets up this overlap with channel 0 wide at slot 10 and channel 1 at slot 11, both on port A. It judges the result by capturing a whole frame and checking that slots 10 and 11 carry channel 0's full word, with port A enabled for exactly 16 cycles. A frame-sync edge that captures data while a sample update arrives in the same frame is also provoked, by changing `ch_data` mid-frame. The bench then checks that the old word is sent in that frame and the new word only in the next one.

// File: rtl/pcm_slot_tx.sv
module pcm_slot_tx #(
  parameter int NCH   = 4,
  parameter int SLOTS = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fsync,
  input  logic                        active,
  input  logic                        sig_en,
  input  logic                        cutoff,
  input  logic [NCH*$clog2(SLOTS)-1:0] ch_slot,
  input  logic [2*NCH-1:0]            ch_port,
  input  logic [NCH-1:0]              ch_wide,
  input  logic [16*NCH-1:0]           ch_data,
  output logic                        txa,
  output logic                        txa_oe,
  output logic                        txb,
  output logic                        txb_oe
);
  localparam int SW    = $clog2(SLOTS);
  localparam int FRAME = SLOTS * 8;
  localparam int PW    = SW + 3;
  localparam logic [PW-1:0] POS_END = PW'(FRAME - 1);
  localparam logic [SW:0]   LAST    = (SW+1)'(SLOTS - 1);

  logic [PW-1:0]       pos;
  logic                synced;
  logic [16*NCH-1:0]   held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      synced <= 1'b0;
      held   <= '0;
    end else if (fsync) begin
      pos    <= '0;
      synced <= 1'b1;
      held   <= ch_data;
    end else begin
      pos <= (pos == POS_END) ? '0 : pos + 1'b1;
    end
  end

  wire [SW:0] cur_slot = {1'b0, pos[PW-1:3]};
  wire [2:0]  bpos     = pos[2:0];
  wire        en       = synced && !cutoff && (active || sig_en);

  logic [NCH-1:0] own, bitv;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire [SW:0]  s      = {1'b0, ch_slot[i*SW +: SW]};
    wire         wide   = ch_wide[i] | sig_en;
    wire         first  = (cur_slot == s);
    wire         second = wide && (s != LAST) && (cur_slot == s + 1'b1);
    wire [15:0]  w      = held[i*16 +: 16];
    wire [7:0]   byt    = (wide && !second) ? w[15:8] : w[7:0];
    assign own[i]  = first | second;
    assign bitv[i] = byt[3'd7 - bpos];
  end

  logic hit_a, hit_b, da, db;

  always_comb begin
    hit_a = 1'b0; da = 1'b0;
    hit_b = 1'b0; db = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (own[i] && ch_port[2*i])   begin hit_a = 1'b1; da = bitv[i]; end
      if (own[i] && ch_port[2*i+1]) begin hit_b = 1'b1; db = bitv[i]; end
    end
  end

  assign txa_oe = en & hit_a;
  assign txb_oe = en & hit_b;
  assign txa    = txa_oe & da;
  assign txb    = txb_oe & db;
endmodule

// File: rtl/pcm_slot_tx_chk.sv
module pcm_slot_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic fsync,
  input logic active,
  input logic sig_en,
  input logic cutoff,
  input logic txa,
  input logic txa_oe,
  input logic txb,
  input logic txb_oe
);
  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n)     seen <= 1'b0;
    else if (fsync) seen <= 1'b1;
  end

  p_presync_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> (!txa_oe && !txb_oe && !txa && !txb));

  p_float_low_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !txa_oe |-> !txa);

  p_float_low_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !txb_oe |-> !txb);

  p_cutoff_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cutoff |-> (!txa_oe && !txb_oe));

  p_inactive_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !sig_en) |-> (!txa_oe && !txb_oe));
endmodule

bind pcm_slot_tx pcm_slot_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .active(active),
  .sig_en(sig_en), .cutoff(cutoff), .txa(txa), .txa_oe(txa_oe),
  .txb(txb), .txb_oe(txb_oe)
);

// File: tb/tb_pcm_slot_tx.sv
module tb_pcm_slot_tx;
  localparam int PERIOD = 10;
  localparam int NCH = 4, SLOTS = 32, SW = 5, FR = SLOTS * 8;

  logic clk = 0, rst_n = 0, fsync = 0, active = 1, sig_en = 0, cutoff = 0;
  logic [NCH*SW-1:0] ch_slot = '0;
  logic [2*NCH-1:0]  ch_port = '0;
  logic [NCH-1:0]    ch_wide = '0;
  logic [16*NCH-1:0] ch_data = '0;
  logic txa, txa_oe, txb, txb_oe;

  int n_chk = 0, n_bad = 0;
  logic ca [FR], cae [FR], cb [FR], cbe [FR];

  always #(PERIOD/2) clk = ~clk;

  pcm_slot_tx #(.NCH(NCH), .SLOTS(SLOTS)) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_cfg();
    @(negedge clk);
    ch_port = '0; ch_wide = '0; ch_slot = '0; ch_data = '0;
    active = 1; sig_en = 0; cutoff = 0;
  endtask

  task automatic cfg(input int ch, input int slot, input logic [1:0] port, input bit wide, input logic [15:0] d);
    ch_slot[ch*SW +: SW] = SW'(slot);
    ch_port[2*ch +: 2]   = port;
    ch_wide[ch]          = wide;
    ch_data[ch*16 +: 16] = d;
  endtask

  task automatic cap_frame(input bit do_sync, input int upd_at, input logic [63:0] upd);
    if (do_sync) begin
      @(negedge clk); fsync = 1;
      @(negedge clk); fsync = 0;
    end else @(negedge clk);
    for (int i = 0; i < FR; i++) begin
      if (i > 0) @(negedge clk);
      ca[i] = txa; cae[i] = txa_oe; cb[i] = txb; cbe[i] = txb_oe;
      if (i == upd_at) ch_data = upd;
    end
  endtask

  task automatic exp_burst(input bit portb, input int slot, input int nb, input logic [15:0] exp, input string tag);
    logic [15:0] act = '0;
    bit ok = 1;
    for (int k = 0; k < nb; k++) begin
      int p = slot*8 + k;
      act = {act[14:0], portb ? cb[p] : ca[p]};
      if (!(portb ? cbe[p] : cae[p])) ok = 0;
    end
    chk(ok && act == exp, tag, act, exp);
  endtask

  task automatic exp_count(input bit portb, input int exp, input string tag);
    int n = 0;
    bit leak = 0;
    for (int p = 0; p < FR; p++) begin
      if (portb ? cbe[p] : cae[p]) n++;
      else if (portb ? cb[p] : ca[p]) leak = 1;
    end
    chk(n == exp && !leak, tag, n, exp);
  endtask

  task automatic t_reset();
    bit ok = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cfg(0, 0, 2'b11, 0, 16'h00FF);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (txa_oe || txb_oe || txa || txb) ok = 0;
    end
    chk(ok, "R1 quiet before first frame sync", {txa_oe, txb_oe}, 0);
  endtask

  task automatic t_basic();
    clear_cfg();
    cfg(0, 2, 2'b01, 0, 16'h77A5);
    cfg(1, 5, 2'b10, 0, 16'h003C);
    cfg(2, 7, 2'b11, 1, 16'hBEEF);
    cfg(3, 9, 2'b00, 0, 16'hFFFF);
    cap_frame(1, -1, '0);
    exp_burst(0, 2, 8, 16'h00A5, "R2 R3 narrow slot 2 port A");
    exp_burst(1, 5, 8, 16'h003C, "R5 narrow port B");
    exp_burst(0, 7, 16, 16'hBEEF, "R4 R5 wide port A");
    exp_burst(1, 7, 16, 16'hBEEF, "R4 R5 wide port B");
    exp_count(0, 24, "R6 port A enabled cycles");
    exp_count(1, 24, "R6 port B enabled cycles");
    cap_frame(0, -1, '0);
    exp_burst(0, 2, 8, 16'h00A5, "R11 wrap repeats slot 2");
    exp_burst(1, 7, 16, 16'hBEEF, "R11 wrap repeats wide");
  endtask

  task automatic t_latch();
    logic [63:0] nv;
    clear_cfg();
    cfg(0, 20, 2'b01, 0, 16'h0011);
    nv = ch_data; nv[15:0] = 16'h0022;
    cap_frame(1, 100, nv);
    exp_burst(0, 20, 8, 16'h0011, "R9 old word kept this frame");
    cap_frame(1, -1, '0);
    exp_burst(0, 20, 8, 16'h0022, "R9 new word next frame");
  endtask

  task automatic t_cutoff();
    clear_cfg();
    cfg(0, 1, 2'b11, 1, 16'h1234);
    cutoff = 1;
    cap_frame(1, -1, '0);
    exp_count(0, 0, "R7 cutoff port A");
    exp_count(1, 0, "R7 cutoff port B");
  endtask

  task automatic t_inactive();
    clear_cfg();
    cfg(0, 3, 2'b01, 0, 16'h1234);
    active = 0;
    cap_frame(1, -1, '0);
    exp_count(0, 0, "R8 inactive no signaling");
    sig_en = 1;
    cap_frame(1, -1, '0);
    exp_burst(0, 3, 16, 16'h1234, "R8 signaling forces 16-bit");
  endtask

  task automatic t_collide();
    clear_cfg();
    cfg(0, 10, 2'b01, 1, 16'hC3A1);
    cfg(1, 11, 2'b01, 0, 16'h00FF);
    cfg(2, 11, 2'b10, 0, 16'h0066);
    cap_frame(1, -1, '0);
    exp_burst(0, 10, 16, 16'hC3A1, "R10 lower channel wins");
    exp_count(0, 16, "R10 loser not output");
    exp_burst(1, 11, 8, 16'h0066, "R10 other port unaffected");
  endtask

  task automatic t_last();
    clear_cfg();
    cfg(0, SLOTS-1, 2'b01, 1, 16'h5AC3);
    cap_frame(1, -1, '0);
    exp_burst(0, SLOTS-1, 8, 16'h005A, "R4 last slot upper byte");
    exp_count(0, 8, "R4 last slot drops second byte");
  endtask

  initial begin
    #(PERIOD*200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_latch();
    t_cutoff();
    t_inactive();
    t_collide();
    t_last();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule